// File: doc/BRIEF.md
# Feedback Butterfly Pair with Multiplier-Free Quarter Rotation

This block is two cascaded single-path butterfly stages for a streaming radix-2 FFT pipeline. Each stage has a feedback register. It takes one complex sample per valid cycle and sends out one complex sample per valid cycle. A valid-driven counter splits each period into two phases. In the loading phase the incoming sample goes into the stage's feedback line, and the stage sends out whatever leaves that line. In the combining phase the stage forms a 2-point DFT of the incoming sample and the held sample. The halved sum goes downstream and the halved difference goes back into the line. The difference then comes out during the next loading phase.

The first stage holds half a frame. The second stage holds a quarter of a frame and sits between the first stage and a later general twiddle multiplier. In the last quarter of each frame it multiplies its incoming sample by -j. This needs no multiplier: the real and imaginary operands are swapped and the add and subtract roles on the imaginary path are exchanged. Every sum and difference is halved with round-half-up, so the word width stays fixed.

Top module: `fbfly_pair`

## Requirements
- R1: While `rst_n` is low, `out_vld` is 0 and `out_re`/`out_im` are 0. Both feedback lines and both phase counters are cleared, so the feedback values first read out after reset are zero.
- R2: Each stage registers its result once, so a sample accepted with `in_vld`=1 gives exactly one output with `out_vld`=1 two clock cycles later.
- R3: A cycle with `in_vld`=0 leaves the phase counters, the feedback lines and `out_re`/`out_im` unchanged.
- R4: Each stage counts its own valid inputs. When the count modulo 2L is below L (loading phase), the input is stored and the output is the value stored L valid inputs earlier.
- R5: When the count modulo 2L is L or more (combining phase), with H the held value and X the input, the output is scale(H+X) and scale(H−X) is stored. This applies to real and imaginary parts separately.
- R6: scale(v) = (v+1) >>> 1 on the exact sum; a result of +32768 saturates to +32767. Samples are 16-bit two's complement.
- R7: L is FFT_N/2 for the first stage and FFT_N/4 for the second. The second stage's counter runs modulo FFT_N.
- R8: In the second stage, when its count modulo FFT_N is 3·FFT_N/4 or more, X is replaced by −j·X = (X.im, −X.re) before the combining step of R5.
- R9: Values written back during a combining phase are emitted, in arrival order, during the following loading phase of the same stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample strobe |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_vld | output | 1 | Output sample strobe |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |

## Verification
Five kinds of input are used. An impulse frame shows where each held sample reappears, which exposes a wrong feedback depth or a wrong phase boundary. Constant and alternating-sign frames make sum and difference clearly different, so a swapped write-back or a wrong rotation sign shows up. Full-scale opposite-sign halves force the +32768 saturation case. Long random frames with random idle gaps stress the odd-value rounding and show whether the counters and outputs hold still while the strobe is low.

// File: rtl/fbfly_pkg.sv
package fbfly_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic signed [SAMPLE_W-1:0] smp_t;
    typedef struct packed {
        smp_t re;
        smp_t im;
    } cplx_t;
endpackage

// File: rtl/fbfly_scale.sv
// Halve an exact sum with round-half-up, clamping the single overflow case.
module fbfly_scale #(
    parameter int W = 16
) (
    input  logic signed [W:0]   val,
    output logic signed [W-1:0] res
);
    localparam logic signed [W+1:0] MAXV = (W+2)'((2 ** (W-1)) - 1);
    localparam logic signed [W+1:0] ONE  = (W+2)'(1);

    logic signed [W+1:0] t_w;
    logic signed [W+1:0] sh_w;

    always_comb begin
        t_w  = $signed({val[W], val}) + ONE;
        sh_w = t_w >>> 1;
        if (sh_w > MAXV) res = MAXV[W-1:0];
        else             res = sh_w[W-1:0];
    end

    // R6: halving a non-negative sum never yields a negative word
    always_comb begin
        if (!$isunknown(val)) begin
            a_r6_sign_kept: assert (val[W] || !res[W-1]);
        end
    end
endmodule

// File: rtl/fbfly_ctrl.sv
// Valid-driven phase counter: selects loading vs combining and the rotation quarter.
module fbfly_ctrl #(
    parameter int DEPTH  = 8,
    parameter bit ROTATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic fill,
    output logic rot_en
);
    localparam int SB = $clog2(DEPTH);
    localparam int CW = SB + 1 + (ROTATE ? 1 : 0);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fill = ~cnt_q[SB];

    generate
        if (ROTATE) begin : g_quarter
            assign rot_en = cnt_q[SB] & cnt_q[SB+1];
        end else begin : g_no_quarter
            assign rot_en = 1'b0;
        end
    endgenerate

    // R3: counter frozen on idle cycles
    a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q));
    // R7: counter steps by one per valid input, wrapping at its period
    a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/fbfly_stage.sv
// One feedback-register butterfly stage, optionally with the -j quarter rotation.
module fbfly_stage
    import fbfly_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter bit ROTATE = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_vld,
    input  cplx_t in_smp,
    output logic  out_vld,
    output cplx_t out_smp
);
    localparam int W = SAMPLE_W;

    typedef struct packed {
        cplx_t smp;
        logic  vld;
    } stage_t;

    stage_t st_d, st_q;
    cplx_t  fb_d [DEPTH];
    cplx_t  fb_q [DEPTH];

    logic fill, rot_en;

    fbfly_ctrl #(.DEPTH(DEPTH), .ROTATE(ROTATE)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_vld),
        .fill   (fill),
        .rot_en (rot_en)
    );

    cplx_t head;
    assign head = fb_q[DEPTH-1];

    logic signed [W:0] h_re, h_im, x_re, x_im, b_re;
    logic signed [W:0]   raw    [4];
    logic signed [W-1:0] scaled [4];

    assign h_re = {head.re[W-1], head.re};
    assign h_im = {head.im[W-1], head.im};
    assign x_re = {in_smp.re[W-1], in_smp.re};
    assign x_im = {in_smp.im[W-1], in_smp.im};

    // Rotation by swap on the real path, add/sub role exchange on the imaginary path.
    always_comb begin
        b_re   = rot_en ? x_im : x_re;
        raw[0] = h_re + b_re;
        raw[2] = h_re - b_re;
        raw[1] = rot_en ? (h_im - x_re) : (h_im + x_im);
        raw[3] = rot_en ? (h_im + x_re) : (h_im - x_im);
    end

    generate
        for (genvar k = 0; k < 4; k++) begin : g_scale
            fbfly_scale #(.W(W)) i_scale (
                .val (raw[k]),
                .res (scaled[k])
            );
        end
    endgenerate

    cplx_t sum_s, dif_s, push_v;
    assign sum_s = '{re: scaled[0], im: scaled[1]};
    assign dif_s = '{re: scaled[2], im: scaled[3]};

    always_comb begin
        st_d     = st_q;
        fb_d     = fb_q;
        push_v   = in_smp;
        st_d.vld = in_vld;
        if (in_vld) begin
            if (fill) begin
                st_d.smp = head;
                push_v   = in_smp;
            end else begin
                st_d.smp = sum_s;
                push_v   = dif_s;
            end
            for (int i = DEPTH - 1; i > 0; i--) fb_d[i] = fb_q[i-1];
            fb_d[0] = push_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) fb_q[i] <= '0;
        end else begin
            st_q <= st_d;
            fb_q <= fb_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_smp = st_q.smp;

    // R2: one register of latency for the strobe
    a_r2_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld));
    // R3: output word frozen on idle cycles
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_smp));
endmodule

// File: rtl/fbfly_pair.sv
module fbfly_pair
    import fbfly_pkg::*;
#(
    parameter int FFT_N = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_re,
    input  logic signed [SAMPLE_W-1:0] in_im,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_re,
    output logic signed [SAMPLE_W-1:0] out_im
);
    localparam int D_FIRST  = FFT_N / 2;
    localparam int D_SECOND = FFT_N / 4;

    cplx_t a_smp, mid_smp, z_smp;
    logic  mid_vld;

    assign a_smp = '{re: in_re, im: in_im};

    fbfly_stage #(.DEPTH(D_FIRST), .ROTATE(1'b0)) i_first (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_smp  (a_smp),
        .out_vld (mid_vld),
        .out_smp (mid_smp)
    );

    fbfly_stage #(.DEPTH(D_SECOND), .ROTATE(1'b1)) i_second (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (mid_vld),
        .in_smp  (mid_smp),
        .out_vld (out_vld),
        .out_smp (z_smp)
    );

    assign out_re = z_smp.re;
    assign out_im = z_smp.im;

    // R2: end-to-end strobe latency of two cycles
    a_r2_pair_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_vld) |=> out_vld);
endmodule

// File: tb/test_fbfly_pair.sv
module test_fbfly_pair;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic out_vld;
    logic signed [15:0] out_re, out_im;

    always #4 clk = ~clk;   // 125 MHz

    fbfly_pair #(.FFT_N(N)) i_fbfly_pair (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
    );

    int total = 0, bad = 0, cyc = 0;
    bit running = 0, done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural model state (R1: everything starts at zero)
    int fbr [2][64];
    int fbi [2][64];
    int mcnt [2];
    bit sat_hit;

    int    q_re[$], q_im[$], q_cyc[$];
    string q_tag[$];

    function automatic int rnd(int v);
        int t;
        t = (v + 1) >>> 1;           // R6
        if (t > 32767) begin t = 32767; sat_hit = 1; end
        return t;
    endfunction

    task automatic mstep(input int s, input int dep, input int xr, input int xi,
                         output int yr, output int yi, output bit comp, output bit rot);
        int per, c, hr, hi, pr, pi, br, bi;
        per  = (s == 1) ? 4 * dep : 2 * dep;       // R7
        c    = mcnt[s];
        comp = (c % (2 * dep)) >= dep;
        rot  = comp && (s == 1) && (c >= 3 * dep); // R8
        hr = fbr[s][dep-1];
        hi = fbi[s][dep-1];
        if (!comp) begin                           // R4, R9
            yr = hr; yi = hi; pr = xr; pi = xi;
        end else begin                             // R5
            br = rot ? xi : xr;
            bi = rot ? -xr : xi;
            yr = rnd(hr + br); yi = rnd(hi + bi);
            pr = rnd(hr - br); pi = rnd(hi - bi);
        end
        for (int i = dep - 1; i > 0; i--) begin
            fbr[s][i] = fbr[s][i-1];
            fbi[s][i] = fbi[s][i-1];
        end
        fbr[s][0] = pr;
        fbi[s][0] = pi;
        mcnt[s] = (c + 1) % per;
    endtask

    task automatic send(input int re, input int im);
        int y1r, y1i, y2r, y2i;
        bit c1, r1, c2, r2;
        string tag;
        @(negedge clk);
        in_vld = 1'b1;
        in_re  = 16'(re);
        in_im  = 16'(im);
        sat_hit = 0;
        mstep(0, N / 2, re, im, y1r, y1i, c1, r1);
        mstep(1, N / 4, y1r, y1i, y2r, y2i, c2, r2);
        tag = r2 ? "R8" : ((c1 || c2) ? "R5" : "R4");
        if (sat_hit) tag = {tag, " R6"};
        q_re.push_back(y2r);
        q_im.push_back(y2i);
        q_cyc.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_re  = 16'($urandom);   // must be ignored (R3)
            in_im  = 16'($urandom);
        end
    endtask

    // scoreboard monitor
    int last_re = 0, last_im = 0;
    always @(negedge clk) begin
        if (running && !done) begin
            if (out_vld) begin
                if (q_re.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R2 unexpected output actual=(%0d,%0d) expected=none",
                             out_re, out_im);
                end else begin
                    int er, ei, ec;
                    string tg;
                    er = q_re.pop_front(); ei = q_im.pop_front();
                    ec = q_cyc.pop_front(); tg = q_tag.pop_front();
                    total++;
                    if (int'(out_re) != er || int'(out_im) != ei) begin
                        bad++;
                        $display("FAIL %s (R7 R9 flow) actual=(%0d,%0d) expected=(%0d,%0d)",
                                 tg, out_re, out_im, er, ei);
                    end
                    total++;
                    if (cyc != ec + 2) begin
                        bad++;
                        $display("FAIL R2 latency actual=%0d expected=%0d", cyc - ec, 2);
                    end
                end
                last_re = int'(out_re);
                last_im = int'(out_im);
            end else begin
                total++;
                if (int'(out_re) != last_re || int'(out_im) != last_im) begin
                    bad++;
                    $display("FAIL R3 idle hold actual=(%0d,%0d) expected=(%0d,%0d)",
                             out_re, out_im, last_re, last_im);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R2 watchdog actual=hung expected=drained");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            mcnt[s] = 0;
            for (int i = 0; i < 64; i++) begin fbr[s][i] = 0; fbi[s][i] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;   // R1 reset state
        if (out_vld !== 1'b0 || out_re !== 16'sd0 || out_im !== 16'sd0) begin
            bad++;
            $display("FAIL R1 reset actual=(%0b,%0d,%0d) expected=(0,0,0)",
                     out_vld, out_re, out_im);
        end
        rst_n = 1'b1;
        running = 1;
        idle(2);

        // impulse frame
        send(1000, -500);
        for (int k = 1; k < N; k++) send(0, 0);
        idle(3);
        // constant frames
        for (int k = 0; k < 2 * N; k++) send(1234, -4321);
        // alternating sign
        for (int k = 0; k < 2 * N; k++) send((k % 2) ? 20000 : -20000, (k % 2) ? -7 : 7);
        // full-scale halves, forcing saturation (R6)
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < N / 2; k++) send(32767, -32768);
            for (int k = 0; k < N / 2; k++) send(-32768, 32767);
        end
        // random frames with idle gaps
        for (int k = 0; k < 30 * N; k++) begin
            send($signed(16'($urandom)), $signed(16'($urandom)));
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
        end
        // flush the pipeline with zero frames
        for (int k = 0; k < 2 * N; k++) send(0, 0);
        idle(1);
        while (q_re.size() != 0) @(negedge clk);
        idle(4);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule